// File: doc/BRIEF.md
# Dual-Width Integer Condition-Code Generator

This block sits behind an integer ALU and turns each finished operation into condition flags. From the two source operands and the ALU result it works out negative, zero, overflow and carry twice over. One set comes from the low 32-bit view, with the sign at bit 31. The other comes from the full 64-bit view, with the sign at bit 63. It then merges the flags into an 8-bit condition-code register.

The operation class selects the flag rules:

- Add and subtract each have their own carry and overflow rules.
- Logical operations derive only negative and zero.

A per-flag update mask picks which register bits are written; every other bit keeps its value. A mode input selects a 64-bit machine, where both nibbles can change, or a 32-bit-only machine, where only the low nibble can change. Updates happen on a rising clock edge while the valid strobe is high.

Top module: `ccflag_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears `cc_q` to 8'h00.
- R2: In each group, N is the group's sign bit of `result` (bit 31 for the low nibble, bit 63 for the high nibble). Z is set when the group's result bits (low 32 bits, or all 64 bits) are all zero. Register layout: `cc_q[7:4]` is the 64-bit group and `cc_q[3:0]` the 32-bit group, each ordered {N,Z,V,C} from its bit 3 down to bit 0.
- R3: For `op_class` 2'b00 (add), C is the group sign bit of `(a & b) | (~result & (a | b))`.
- R4: For add, V is set when both sources share a sign and the result sign differs from it. This is the group sign bit of `(b ^ result) & (a ^ ~b)`.
- R5: For `op_class` 2'b01 (subtract a - b), C is set when `b` is unsigned-greater than `a`. The compare is over 32 bits for the low group and 64 bits for the high group.
- R6: For subtract, V is the group sign bit of `(a ^ b) & (a ^ result)`.
- R7: For `op_class` 2'b10 (logical), V and C are written as 0 and N, Z follow R2.
- R8: On an update, bit i of `cc_q` takes the new flag when `upd_mask[i]` is 1 and keeps its old value when it is 0.
- R9: With `wide_mode` 0, `cc_q[7:4]` is never changed by an update.
- R10: `op_class` 2'b11 leaves `cc_q` unchanged.
- R11: With `upd_valid` low, `cc_q` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Write strobe for the flag register |
| op_class | input | 2 | 00 add, 01 subtract, 10 logical, 11 reserved |
| wide_mode | input | 1 | 1 = 64-bit machine, 0 = 32-bit-only machine |
| upd_mask | input | 8 | Per-bit write enable for `cc_q` |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| result | input | 64 | ALU result |
| cc_q | output | 8 | Condition-code register, {wide NZVC, narrow NZVC} |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath with a 32-bit narrow view. These defaults put both sign positions, 31 and 63, in play at once. The chosen operands make the two groups disagree: a carry out of bit 31 with none out of bit 63, and an overflow only at bit 63. An unsigned borrow also appears in the low half but not in the full width. A wrong bit index or a compare width taken from the other group is therefore visible in a single register value.

// File: rtl/ccflag_pkg.sv
// Package: shared encodings for the condition-code generator.
// Assumes a 4-bit flag group ordered {N,Z,V,C}.
package ccflag_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGIC = 2'b10,
        OPC_RSVD  = 2'b11
    } opc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    localparam int GRP_W = 4;

endpackage

// File: rtl/ccflag_group.sv
// Module: ccflag_group
// Computes one NZVC group for a W-bit view of an ALU operation.
// Assumes the operands are already truncated to W bits by the caller.
// A reserved class yields all-zero flags; the caller suppresses the write.
module ccflag_group
    import ccflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  opc_e         opc,
    output nzvc_t        flags
);

    localparam int MSB = W - 1;

    logic [W-1:0] add_cy_vec;
    logic [W-1:0] add_ov_vec;
    logic [W-1:0] sub_ov_vec;

    // Bitwise terms whose top bit gives carry and overflow.
    always_comb begin
        add_cy_vec = (a & b) | (~r & (a | b));
        add_ov_vec = (b ^ r) & (a ^ ~b);
        sub_ov_vec = (a ^ b) & (a ^ r);
    end

    // Select the flag rules for the operation class.
    always_comb begin
        flags   = '0;
        flags.n = r[MSB];
        flags.z = (r == '0);
        unique case (opc)
            OPC_ADD: begin
                flags.c = add_cy_vec[MSB];
                flags.v = add_ov_vec[MSB];
            end
            OPC_SUB: begin
                flags.c = (b > a);
                flags.v = sub_ov_vec[MSB];
            end
            OPC_LOGIC: begin
                flags.c = 1'b0;
                flags.v = 1'b0;
            end
            default: flags = '0;
        endcase
    end

endmodule

// File: rtl/ccflag_reg.sv
// Module: ccflag_reg
// Masked merge register for the condition codes.
// Assumes the caller has already folded mode and class into wr_en and wr_mask.
module ccflag_reg #(
    parameter int CC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CC_W-1:0] wr_mask,
    input  logic [CC_W-1:0] wr_data,
    output logic [CC_W-1:0] cc_q
);

    logic [CC_W-1:0] cc_d;

    // Merge: masked bits take new data, the others hold.
    always_comb begin
        cc_d = (cc_q & ~wr_mask) | (wr_data & wr_mask);
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= '0;
        else if (wr_en)
            cc_q <= cc_d;
    end

    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cc_q ^ $past(cc_q)) & ~$past(wr_mask)) == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cc_q));

endmodule

// File: rtl/ccflag_unit.sv
// Module: ccflag_unit (top)
// Produces narrow (bit 31) and wide (bit 63) NZVC groups from an ALU
// operation and merges them into an 8-bit register {wide, narrow}.
// Assumes NARROW_W < DATA_W; wide_mode=0 freezes the wide nibble.
module ccflag_unit
    import ccflag_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [1:0]        op_class,
    input  logic              wide_mode,
    input  logic [7:0]        upd_mask,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] result,
    output logic [7:0]        cc_q
);

    localparam int NGRP = 2;
    localparam int CC_W = NGRP * GRP_W;

    opc_e            opc;
    nzvc_t           grp_flags [NGRP];
    logic [CC_W-1:0] new_flags;
    logic [CC_W-1:0] eff_mask;
    logic            wr_en;

    // Interpret the raw class field.
    always_comb opc = opc_e'(op_class);

    // One flag group per view width: index 0 narrow, index 1 wide.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int GW = (g == 0) ? NARROW_W : DATA_W;
        ccflag_group #(.W(GW)) u_grp (
            .a     (src_a[GW-1:0]),
            .b     (src_b[GW-1:0]),
            .r     (result[GW-1:0]),
            .opc   (opc),
            .flags (grp_flags[g])
        );
    end

    // Pack the groups, gate the wide nibble by mode, qualify the write.
    always_comb begin
        new_flags = {grp_flags[1], grp_flags[0]};
        eff_mask  = upd_mask & {{GRP_W{wide_mode}}, {GRP_W{1'b1}}};
        wr_en     = upd_valid && (opc != OPC_RSVD);
    end

    ccflag_reg #(.CC_W(CC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (eff_mask),
        .wr_data (new_flags),
        .cc_q    (cc_q)
    );

    // R7
    logic_vc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_LOGIC) |-> (!grp_flags[0].v && !grp_flags[0].c &&
                                !grp_flags[1].v && !grp_flags[1].c));

    // R9
    narrow_keeps_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |=> $stable(cc_q[7:4]));

    // R10
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && op_class == 2'b11) |=> $stable(cc_q));

    // R2
    zero_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_RSVD && grp_flags[1].z) |-> grp_flags[0].z);

endmodule

// File: tb/ccflag_unit_test.sv
module ccflag_unit_test;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic [7:0]  exp;
    } vec_t;

    // Wide mode, full mask; each row fully determines cc_q.
    localparam vec_t VECS [8] = '{
        '{4'd3, 2'b00, 64'h1, 64'h1, 64'h2, 8'h00},                          // R3 plain add
        '{4'd3, 2'b00, 64'hFFFF_FFFF, 64'h1, 64'h1_0000_0000, 8'h05},         // R3 carry bit31 only
        '{4'd4, 2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,
                       64'h8000_0000_0000_0000, 8'hA5},                       // R4 overflow bit63
        '{4'd5, 2'b01, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 8'h99},         // R5 borrow both
        '{4'd6, 2'b01, 64'h8000_0000_0000_0000, 64'h1,
                       64'h7FFF_FFFF_FFFF_FFFF, 8'h29},                       // R6 wide ovf, narrow borrow
        '{4'd2, 2'b01, 64'h123, 64'h123, 64'h0, 8'h44},                       // R2 zero both
        '{4'd7, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                       64'hFFFF_FFFF_0000_0000, 8'h84},                       // R7 logical N/Z only
        '{4'd7, 2'b10, 64'h0, 64'h0, 64'h0, 8'h44}                            // R7 logical zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic        wide_mode = 1'b1;
    logic [7:0]  upd_mask = 8'h00;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result = '0;
    logic [7:0]  cc_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccflag_unit uut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
        .wide_mode(wide_mode), .upd_mask(upd_mask), .src_a(src_a),
        .src_b(src_b), .result(result), .cc_q(cc_q)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (cc_q !== exp) begin
            errors++;
            $display("FAIL %s cc_q=%h expected=%h", req, cc_q, exp);
        end
    endtask

    // Drive one operation at a falling edge, then sample at the next falling edge.
    task automatic apply(input logic v, input logic [1:0] op, input logic w,
                         input logic [7:0] m, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] r);
        upd_valid = v; op_class = op; wide_mode = w; upd_mask = m;
        src_a = a; src_b = b; result = r;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 8'h00);

        foreach (VECS[i]) begin
            apply(1'b1, VECS[i].op, 1'b1, 8'hFF, VECS[i].a, VECS[i].b, VECS[i].r);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
        end

        // R8: low nibble only; state 0x44, new flags 0xA5
        apply(1'b1, 2'b00, 1'b1, 8'h0F, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,
              64'h8000_0000_0000_0000);
        check("R8 mask", 8'h45);

        // R9: narrow mode with full mask; new narrow 9, wide nibble kept
        apply(1'b1, 2'b01, 1'b0, 8'hFF, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE);
        check("R9 narrow mode", 8'h49);

        // R10: reserved class
        apply(1'b1, 2'b11, 1'b1, 8'hFF, 64'h0, 64'h0, 64'h0);
        check("R10 reserved class", 8'h49);

        // R11: strobe low
        apply(1'b0, 2'b00, 1'b1, 8'hFF, 64'h0, 64'h0, 64'h0);
        check("R11 no strobe", 8'h49);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset mid-run", 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule